// File: doc/BRIEF.md
# Scratch-Memory Word Address Selector

This block forms the address into a small scratch memory of 36-bit words. The memory is divided into 16-word blocks. A block register picks the block, and a 4-bit word index picks one of the 16 words inside it. Each access takes its word index from one of several places:

- the accumulator field of the instruction word;
- the index field of the instruction word;
- the low bits of the memory address register;
- a literal from the control word;
- a counter register. The counter can be read as it stands, or read and then stepped by one.

The block holds the storage itself as a synchronous-write, combinational-read array. It also raises a condition flag when the memory address register holds an accumulator number. The control sequencer drives the source select, the strobes and the load bus each cycle. The instruction word and the memory address register come from outside.

Top module: `acc_addr_sel`

## Requirements
- R1: With `src_sel` = 0, the word index is the accumulator field. This is instruction bits 9 to 12, counting bit 0 as the most significant of the 36, so it is `ir[26:23]` with `ir[26]` as the index MSB.
- R2: With `src_sel` = 1, the word index is the index field. This is instruction bits 14 to 17 in the same numbering, which is `ir[21:18]`.
- R3: With `src_sel` = 2, the word index is `ma[3:0]`.
- R4: With `src_sel` = 3, the word index is the counter value, and the counter does not change.
- R5: With `src_sel` = 4 and `acc_en` high, the access uses the present counter value, and the counter then advances by one at the clock edge. It wraps from 15 to 0.
- R6: `cnt_ld` loads `bus_in[3:0]` into the counter at the clock edge. A load wins over a step in the same cycle.
- R7: With `src_sel` = 5, the word index is `{1'b0, lit}`, so only words 0 to 7 of the block are reached. The codes 6 and 7 give word index 0.
- R8: `blk_ld` loads `bus_in[3:0]` into the block register at the clock edge. `mem_addr` is `{block, word index}`.
- R9: When `wr_en` is high, `wr_data` is written at the clock edge to the word at `mem_addr`. `rd_data` shows the word at the current `mem_addr` without a clock delay. A write to one block leaves the same word in other blocks unchanged.
- R10: `ma_is_ac` is high exactly when `ma` is below 16, that is, when every bit of `ma` above bit 3 is zero.
- R11: After reset, the block register and the counter are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir | input | 36 | Instruction word |
| ma | input | 18 | Memory address register |
| src_sel | input | 3 | Word index source code |
| lit | input | 3 | Literal word number |
| acc_en | input | 1 | Access strobe; allows the counter step |
| cnt_ld | input | 1 | Load counter from bus |
| blk_ld | input | 1 | Load block register from bus |
| bus_in | input | 36 | Load bus |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Write data |
| rd_data | output | 36 | Word at `mem_addr` |
| mem_addr | output | 8 | Full memory address |
| ma_is_ac | output | 1 | Memory address holds an accumulator number |

## Verification
The hardest states to reach from the ports are the counter rolling from 15 to 0, and a load colliding with a step. The counter is only seen through `mem_addr`. The stimulus therefore loads 14 through the bus and then runs back-to-back read-and-step accesses across the wrap. After that it raises `cnt_ld` in the same cycle as a step. Block separation is shown by filling words through the stepping counter, writing a different block at the same word, and then reading the first block back through the literal source.

// File: rtl/acsel_pkg.sv
package acsel_pkg;
  typedef enum logic [2:0] {
    SRC_AC   = 3'd0,
    SRC_IDX  = 3'd1,
    SRC_MA   = 3'd2,
    SRC_CNT  = 3'd3,
    SRC_CINC = 3'd4,
    SRC_LIT  = 3'd5
  } src_e;
endpackage

// File: rtl/ac_counter.sv
module ac_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= step(cnt);
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> (cnt == W'($past(cnt) + 1)));
  // R6
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(cnt));
endmodule

// File: rtl/word_index_mux.sv
module word_index_mux
  import acsel_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LIT_W = 3
) (
  input  logic [2:0]       sel,
  input  logic [IDX_W-1:0] ac_f,
  input  logic [IDX_W-1:0] idx_f,
  input  logic [IDX_W-1:0] ma_f,
  input  logic [IDX_W-1:0] cnt,
  input  logic [LIT_W-1:0] lit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    case (src_e'(sel))
      SRC_AC:   idx = ac_f;
      SRC_IDX:  idx = idx_f;
      SRC_MA:   idx = ma_f;
      SRC_CNT,
      SRC_CINC: idx = cnt;
      SRC_LIT:  idx = IDX_W'(lit);
      default:  idx = '0;
    endcase
  end
endmodule

// File: rtl/scratch_ram.sv
module scratch_ram #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/acc_addr_sel.sv
module acc_addr_sel
  import acsel_pkg::*;
#(
  parameter int IR_W   = 36,
  parameter int DATA_W = 36,
  parameter int MA_W   = 18,
  parameter int IDX_W  = 4,
  parameter int BLK_W  = 4,
  parameter int LIT_W  = 3,
  parameter int BUS_W  = 36
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IR_W-1:0]        ir,
  input  logic [MA_W-1:0]        ma,
  input  logic [2:0]             src_sel,
  input  logic [LIT_W-1:0]       lit,
  input  logic                   acc_en,
  input  logic                   cnt_ld,
  input  logic                   blk_ld,
  input  logic [BUS_W-1:0]       bus_in,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [DATA_W-1:0]      rd_data,
  output logic [BLK_W+IDX_W-1:0] mem_addr,
  output logic                   ma_is_ac
);
  localparam int AW      = BLK_W + IDX_W;
  localparam int AC_LSB  = IR_W - 13;
  localparam int IDX_LSB = IR_W - 18;
  localparam int LDW     = (BLK_W > IDX_W) ? BLK_W : IDX_W;

  function automatic logic ac_range(input logic [MA_W-1:0] m);
    return (m >> IDX_W) == '0;
  endfunction

  logic [BLK_W-1:0] blk_q;
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] word_idx;
  logic             cnt_step;
  logic             unused_bits;

  assign cnt_step = acc_en && (src_sel == SRC_CINC);
  assign unused_bits = ^{ir[IR_W-1:AC_LSB+IDX_W], ir[AC_LSB-1:IDX_LSB+IDX_W],
                         ir[IDX_LSB-1:0], bus_in[BUS_W-1:LDW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= '0;
    else if (blk_ld) blk_q <= bus_in[BLK_W-1:0];
  end

  ac_counter #(.W(IDX_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(cnt_ld), .ld_val(bus_in[IDX_W-1:0]),
    .inc(cnt_step), .cnt(cnt_q)
  );

  word_index_mux #(.IDX_W(IDX_W), .LIT_W(LIT_W)) u_mux (
    .sel(src_sel),
    .ac_f(ir[AC_LSB +: IDX_W]),
    .idx_f(ir[IDX_LSB +: IDX_W]),
    .ma_f(ma[IDX_W-1:0]),
    .cnt(cnt_q),
    .lit(lit),
    .idx(word_idx)
  );

  assign mem_addr = {blk_q, word_idx};
  assign ma_is_ac = ac_range(ma);

  scratch_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .clk(clk), .we(wr_en), .addr(mem_addr), .wdata(wr_data), .rdata(rd_data)
  );

  // R8
  blk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ld |=> (mem_addr[AW-1:IDX_W] == $past(bus_in[BLK_W-1:0])));
  // R9
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem_addr != $past(mem_addr)) || (rd_data == $past(wr_data))));
  // R7
  lit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_LIT) |-> (word_idx[IDX_W-1:LIT_W] == '0));
  // R10
  ma_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_MA && ma_is_ac) |-> (mem_addr[IDX_W-1:0] == ma[IDX_W-1:0]));
endmodule

// File: tb/tb_acc_addr_sel.sv
module tb_acc_addr_sel;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [35:0] ir = '0;
  logic [17:0] ma = '0;
  logic [2:0]  src_sel = 3'd0;
  logic [2:0]  lit = '0;
  logic        acc_en = 0, cnt_ld = 0, blk_ld = 0, wr_en = 0;
  logic [35:0] bus_in = '0, wr_data = '0;
  logic [35:0] rd_data;
  logic [7:0]  mem_addr;
  logic        ma_is_ac;

  int checks = 0, errors = 0;
  logic [3:0] blk_exp = 0;

  always #5 clk = ~clk;

  acc_addr_sel dut (
    .clk(clk), .rst_n(rst_n), .ir(ir), .ma(ma), .src_sel(src_sel), .lit(lit),
    .acc_en(acc_en), .cnt_ld(cnt_ld), .blk_ld(blk_ld), .bus_in(bus_in),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .mem_addr(mem_addr),
    .ma_is_ac(ma_is_ac)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // field taken from MSB-first bit numbers lo..hi
  function automatic logic [3:0] msb_field(input logic [35:0] w, input int first);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++) r = {r[2:0], w[35 - (first + k)]};
    return r;
  endfunction

  task automatic edge_step();
    @(negedge clk);
  endtask

  task automatic set_blk(input logic [3:0] b);
    edge_step(); blk_ld = 1; bus_in = {32'hFFFF_FFF0, b};
    edge_step(); blk_ld = 0; bus_in = '0; blk_exp = b;
  endtask

  task automatic t_reset();
    edge_step(); src_sel = 3; #1;
    check("R11 addr after reset", mem_addr, 8'h00);
  endtask

  task automatic t_ir_fields();
    logic [35:0] pats [3];
    pats[0] = 36'h5_A5A5_A5A5; pats[1] = 36'h0_0400_0000; pats[2] = 36'hF_C3C3_3C3C;
    set_blk(4'hA);
    for (int i = 0; i < 3; i++) begin
      edge_step(); ir = pats[i]; src_sel = 0; #1;
      check("R1 ac field", mem_addr, {blk_exp, msb_field(pats[i], 9)});
      src_sel = 1; #1;
      check("R2 index field", mem_addr, {blk_exp, msb_field(pats[i], 14)});
    end
    check("R8 block part", mem_addr[7:4], 4'hA);
  endtask

  task automatic t_ma();
    logic [17:0] vals [4];
    vals[0] = 18'd5; vals[1] = 18'd15; vals[2] = 18'd16; vals[3] = 18'h20003;
    for (int i = 0; i < 4; i++) begin
      edge_step(); ma = vals[i]; src_sel = 2; #1;
      check("R3 ma low bits", mem_addr, {blk_exp, vals[i][3:0]});
      check("R10 ma_is_ac", ma_is_ac, (vals[i] < 18'd16));
    end
  endtask

  task automatic t_counter();
    edge_step(); cnt_ld = 1; bus_in = 36'hFFFF_FFFE; src_sel = 0;
    edge_step(); cnt_ld = 0; bus_in = '0; src_sel = 3; #1;
    check("R6 load value", mem_addr[3:0], 4'd14);
    edge_step(); #1;
    check("R4 counter held", mem_addr[3:0], 4'd14);
    edge_step(); src_sel = 4; acc_en = 1; #1;
    check("R5 uses current", mem_addr[3:0], 4'd14);
    edge_step(); #1;
    check("R5 step to 15", mem_addr[3:0], 4'd15);
    edge_step(); #1;
    check("R5 wrap to 0", mem_addr[3:0], 4'd0);
    edge_step(); cnt_ld = 1; bus_in = 36'd3;
    edge_step(); cnt_ld = 0; acc_en = 0; src_sel = 3; bus_in = '0; #1;
    check("R6 load beats step", mem_addr[3:0], 4'd3);
    edge_step(); src_sel = 4; #1;
    edge_step(); #1;
    check("R5 no step without acc_en", mem_addr[3:0], 4'd3);
  endtask

  task automatic t_lit();
    for (int i = 0; i < 8; i += 7) begin
      edge_step(); src_sel = 5; lit = 3'(i); #1;
      check("R7 literal", mem_addr, {blk_exp, 4'(i)});
    end
    edge_step(); src_sel = 6; #1;
    check("R7 code 6", mem_addr[3:0], 4'd0);
  endtask

  function automatic logic [35:0] pat(input int i);
    return 36'h9_1234_5670 ^ (36'(i) * 36'h1_0101_0101);
  endfunction

  task automatic t_mem();
    set_blk(4'd2);
    edge_step(); cnt_ld = 1; bus_in = '0;
    edge_step(); cnt_ld = 0;
    for (int i = 0; i < 4; i++) begin
      src_sel = 4; acc_en = 1; wr_en = 1; wr_data = pat(i);
      edge_step();
    end
    acc_en = 0; wr_en = 0;
    for (int i = 0; i < 4; i++) begin
      src_sel = 5; lit = 3'(i); #1;
      check("R9 readback", rd_data, pat(i));
      edge_step();
    end
    set_blk(4'd3);
    src_sel = 5; lit = 0; wr_en = 1; wr_data = 36'hD_EAD0_BEEF;
    edge_step(); wr_en = 0; #1;
    check("R9 other block write", rd_data, 36'hD_EAD0_BEEF);
    check("R8 addr block 3", mem_addr, 8'h30);
    set_blk(4'd2);
    src_sel = 5; lit = 0; #1;
    check("R9 block isolation", rd_data, pat(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ir_fields();
    t_ma();
    t_counter();
    t_lit();
    t_mem();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule